// File: doc/BRIEF.md
# Secondary Processor Bus Address Decoder

This block sits between the secondary processor's memory port and the memories and peripherals behind it. Each request (address, read or write, access size, the processor's program counter and a BIOS protection bound) is decoded into a region code, a one-hot target select and a local address trimmed to the target's size. Read data from the selected target comes back on a shared ready/data pair and is returned to the processor, zero-extended to the access size.

Two cases change the sequence. A BIOS read that the program counter is not allowed to see never reaches the BIOS target: the decoder answers with all ones at once. A 32-bit access to the 16-bit wireless window is turned into two 16-bit transfers, low half first, while `busy` stays high. A request is taken only while `busy` is low.

The control is a five-state machine. ST_IDLE waits for `req_valid`. It moves to ST_DONE for unmapped or protected accesses, to ST_SPLIT_LO for a 32-bit wireless access, and to ST_SINGLE otherwise. ST_SINGLE moves to ST_DONE on `tgt_rdy`. ST_SPLIT_LO moves to ST_SPLIT_HI on `tgt_rdy`. ST_SPLIT_HI moves to ST_DONE on `tgt_rdy`. ST_DONE returns to ST_IDLE after one cycle.

Top module: `aux_bus_decoder`

## Requirements
- R1: A read below 0x4000 selects the BIOS target (`tgt_sel` bit 0) with region code 1 and local address addr[13:0]. A write below 0x4000 is unmapped.
- R2: A BIOS read is protected when the program counter is at or above 0x4000, or when the address is below `bios_bound` and the program counter is at or above `bios_bound`. A protected read selects no target, reports region 1 and returns all ones in the access size (0xFF, 0xFFFF, 0xFFFFFFFF).
- R3: addr[31:23] of 0x004 or 0x005 (0x02000000, 0x02800000) selects main RAM (bit 1), region 2, local address addr modulo 2^MAIN_AW (4 MiB by default).
- R4: addr[31:23] = 0x006 selects shared RAM (bit 2, region 3, addr modulo 2^SHARED_AW, 32 KiB by default) when `shared_grant` is high. Otherwise it selects private RAM (bit 3, region 4, addr[15:0]).
- R5: addr[31:23] = 0x007 always selects private RAM, region 4, local address addr[15:0].
- R6: addr[31:23] = 0x008 selects I/O (bit 4, region 5, addr[23:0]). 0x00C and 0x00D select video RAM (bit 6, region 8, addr modulo 2^VRAM_AW, 256 KiB by default).
- R7: addr[31:23] = 0x009 selects the wireless target (bit 5, local addr[15:0]) only when addr[22:16] is zero and the size is 16 or 32 bit. The region is 7 when addr[15] is set and 6 when it is clear. Any other access in this window is unmapped.
- R8: A 32-bit wireless access makes two 16-bit handshakes. The first is at local address a and the second at a+2 (modulo 2^16). `tgt_wdata[15:0]` carries write bits [15:0] and then [31:16]. Read data is {second half, first half}.
- R9: An unmapped access selects no target, reports region 0 and returns read data 0.
- R10: The select and local address appear in the cycle after the request and hold while `tgt_rdy` is low. `rsp_valid` is a one-cycle pulse in the cycle after the last handshake, or in the cycle after the request when no target is used. `busy` is high from the cycle after the request through the response cycle. Reads of size 8 or 16 are zero-extended, and writes return 0. Size codes are 0 = 8, 1 = 16 and 2 = 32 bit.
- R11: After reset `busy`, `rsp_valid` and `tgt_sel` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8, 1 = 16, 2 = 32 bit |
| req_addr | input | 32 | Processor address |
| req_wdata | input | 32 | Write data, right-aligned |
| cpu_pc | input | 32 | Current program counter |
| bios_bound | input | 32 | BIOS read protection bound |
| shared_grant | input | 1 | Shared RAM is allocated to this processor |
| tgt_sel | output | 7 | One-hot target select: BIOS, main, shared, private, I/O, wireless, video |
| tgt_addr | output | 32 | Local address inside the target |
| tgt_write | output | 1 | Target write strobe |
| tgt_size | output | 2 | Size of the target transfer |
| tgt_wdata | output | 32 | Write data to the target |
| tgt_rdy | input | 1 | Target completes the transfer this cycle |
| tgt_rdata | input | 32 | Target read data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data or override |
| rsp_region | output | 4 | Region code, valid with rsp_valid |
| busy | output | 1 | Access in progress |

## Verification
The decode is registered, so select, local address, size and write data are due one cycle after the request. The bench drives every input at a falling edge and reads these outputs at the next falling edge. Each target handshake happens on the rising edge after the bench raises `tgt_rdy`. The bench therefore requires `rsp_valid` at the falling edge right after the last handshake, and for unmapped or protected accesses at the first falling edge after the request. It flags a response that comes early, comes late or is missing, and it counts handshakes so that a split transfer must show exactly two.

// File: rtl/aux_dec_pkg.sv
package aux_dec_pkg;

    typedef enum logic [3:0] {
        RG_VOID   = 4'd0,
        RG_BIOS   = 4'd1,
        RG_MAIN   = 4'd2,
        RG_SHARED = 4'd3,
        RG_PRIV   = 4'd4,
        RG_IO     = 4'd5,
        RG_WL0    = 4'd6,
        RG_WL1    = 4'd7,
        RG_VRAM   = 4'd8
    } region_e;

    localparam int NTGT  = 7;
    localparam int TGT_W = $clog2(NTGT);

    localparam logic [TGT_W-1:0] TGT_BIOS   = 3'd0;
    localparam logic [TGT_W-1:0] TGT_MAIN   = 3'd1;
    localparam logic [TGT_W-1:0] TGT_SHARED = 3'd2;
    localparam logic [TGT_W-1:0] TGT_PRIV   = 3'd3;
    localparam logic [TGT_W-1:0] TGT_IO     = 3'd4;
    localparam logic [TGT_W-1:0] TGT_WIFI   = 3'd5;
    localparam logic [TGT_W-1:0] TGT_VRAM   = 3'd6;

    localparam logic [1:0] SZ8  = 2'd0;
    localparam logic [1:0] SZ16 = 2'd1;
    localparam logic [1:0] SZ32 = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_SPLIT_LO,
        ST_SPLIT_HI,
        ST_DONE
    } state_e;

    typedef struct packed {
        region_e          region;
        logic [TGT_W-1:0] tgt;
        logic [31:0]      local_addr;
        logic             mapped;
        logic             split;
    } route_t;

endpackage

// File: rtl/aux_region_map.sv
module aux_region_map
    import aux_dec_pkg::*;
#(
    parameter int MAIN_AW   = 22,
    parameter int SHARED_AW = 15,
    parameter int PRIV_AW   = 16,
    parameter int VRAM_AW   = 18,
    parameter int IO_AW     = 24,
    parameter int BIOS_AW   = 14,
    parameter int WIFI_AW   = 16
) (
    input  logic [31:0] addr,
    input  logic        write,
    input  logic [1:0]  size,
    input  logic        shared_grant,
    output route_t      route
);
    localparam logic [31:0] MAIN_MASK   = 32'((64'd1 << MAIN_AW) - 64'd1);
    localparam logic [31:0] SHARED_MASK = 32'((64'd1 << SHARED_AW) - 64'd1);
    localparam logic [31:0] PRIV_MASK   = 32'((64'd1 << PRIV_AW) - 64'd1);
    localparam logic [31:0] VRAM_MASK   = 32'((64'd1 << VRAM_AW) - 64'd1);
    localparam logic [31:0] IO_MASK     = 32'((64'd1 << IO_AW) - 64'd1);
    localparam logic [31:0] BIOS_MASK   = 32'((64'd1 << BIOS_AW) - 64'd1);
    localparam logic [31:0] WIFI_MASK   = 32'((64'd1 << WIFI_AW) - 64'd1);

    logic below_bios;
    logic wifi_ok;

    always_comb begin
        below_bios = ((addr & ~BIOS_MASK) == 32'd0);
        wifi_ok    = (addr[22:16] == 7'd0) && (size != SZ8);
    end

    always_comb begin
        route            = '0;
        route.region     = RG_VOID;
        if (below_bios) begin
            if (!write) begin
                route.region     = RG_BIOS;
                route.tgt        = TGT_BIOS;
                route.local_addr = addr & BIOS_MASK;
                route.mapped     = 1'b1;
            end
        end else begin
            case (addr[31:23])
                9'h004, 9'h005: begin
                    route.region     = RG_MAIN;
                    route.tgt        = TGT_MAIN;
                    route.local_addr = addr & MAIN_MASK;
                    route.mapped     = 1'b1;
                end
                9'h006: begin
                    route.mapped = 1'b1;
                    if (shared_grant) begin
                        route.region     = RG_SHARED;
                        route.tgt        = TGT_SHARED;
                        route.local_addr = addr & SHARED_MASK;
                    end else begin
                        route.region     = RG_PRIV;
                        route.tgt        = TGT_PRIV;
                        route.local_addr = addr & PRIV_MASK;
                    end
                end
                9'h007: begin
                    route.region     = RG_PRIV;
                    route.tgt        = TGT_PRIV;
                    route.local_addr = addr & PRIV_MASK;
                    route.mapped     = 1'b1;
                end
                9'h008: begin
                    route.region     = RG_IO;
                    route.tgt        = TGT_IO;
                    route.local_addr = addr & IO_MASK;
                    route.mapped     = 1'b1;
                end
                9'h009: begin
                    if (wifi_ok) begin
                        route.region     = addr[15] ? RG_WL1 : RG_WL0;
                        route.tgt        = TGT_WIFI;
                        route.local_addr = addr & WIFI_MASK;
                        route.mapped     = 1'b1;
                        route.split      = (size == SZ32);
                    end
                end
                9'h00C, 9'h00D: begin
                    route.region     = RG_VRAM;
                    route.tgt        = TGT_VRAM;
                    route.local_addr = addr & VRAM_MASK;
                    route.mapped     = 1'b1;
                end
                default: begin
                    route.region = RG_VOID;
                end
            endcase
        end
    end
endmodule

// File: rtl/aux_bios_guard.sv
module aux_bios_guard #(
    parameter int BIOS_AW = 14
) (
    input  logic        check,
    input  logic [31:0] addr,
    input  logic [31:0] pc,
    input  logic [31:0] bound,
    output logic        lock
);
    localparam logic [31:0] BIOS_TOP = 32'(64'd1 << BIOS_AW);

    logic pc_outside;
    logic bound_hit;

    always_comb begin
        pc_outside = (pc >= BIOS_TOP);
        bound_hit  = (addr < bound) && (pc >= bound);
        lock       = check && (pc_outside || bound_hit);
    end
endmodule

// File: rtl/aux_size_fit.sv
module aux_size_fit
    import aux_dec_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    always_comb begin
        case (size)
            SZ8:     dout = {24'd0, din[7:0]};
            SZ16:    dout = {16'd0, din[15:0]};
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/aux_sel_decode.sv
module aux_sel_decode #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  sel
);
    for (genvar g = 0; g < N; g++) begin : g_sel
        assign sel[g] = en && (32'(idx) == g);
    end
endmodule

// File: rtl/aux_bus_decoder.sv
module aux_bus_decoder
    import aux_dec_pkg::*;
#(
    parameter int MAIN_AW   = 22,
    parameter int SHARED_AW = 15,
    parameter int VRAM_AW   = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] cpu_pc,
    input  logic [31:0] bios_bound,
    input  logic        shared_grant,
    output logic [6:0]  tgt_sel,
    output logic [31:0] tgt_addr,
    output logic        tgt_write,
    output logic [1:0]  tgt_size,
    output logic [31:0] tgt_wdata,
    input  logic        tgt_rdy,
    input  logic [31:0] tgt_rdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic [3:0]  rsp_region,
    output logic        busy
);
    localparam int PRIV_AW = 16;
    localparam int BIOS_AW = 14;
    localparam int HALF_W  = 16;

    state_e      state_q, state_d;
    route_t      route_d, ctx_q;
    logic        lock_d;
    logic [1:0]  size_q;
    logic        write_q;
    logic [31:0] wdata_q;
    logic [31:0] rdata_q;
    logic [31:0] ones_fit;
    logic [31:0] cap_fit;
    logic        active;

    aux_region_map #(
        .MAIN_AW  (MAIN_AW),
        .SHARED_AW(SHARED_AW),
        .PRIV_AW  (PRIV_AW),
        .VRAM_AW  (VRAM_AW),
        .IO_AW    (24),
        .BIOS_AW  (BIOS_AW),
        .WIFI_AW  (HALF_W)
    ) u_map (
        .addr        (req_addr),
        .write       (req_write),
        .size        (req_size),
        .shared_grant(shared_grant),
        .route       (route_d)
    );

    aux_bios_guard #(.BIOS_AW(BIOS_AW)) u_guard (
        .check(route_d.region == RG_BIOS),
        .addr (req_addr),
        .pc   (cpu_pc),
        .bound(bios_bound),
        .lock (lock_d)
    );

    aux_size_fit u_ones (
        .size(req_size),
        .din (32'hFFFF_FFFF),
        .dout(ones_fit)
    );

    aux_size_fit u_cap (
        .size(size_q),
        .din (tgt_rdata),
        .dout(cap_fit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!route_d.mapped || lock_d) state_d = ST_DONE;
                    else if (route_d.split)        state_d = ST_SPLIT_LO;
                    else                           state_d = ST_SINGLE;
                end
            end
            ST_SINGLE:   if (tgt_rdy) state_d = ST_DONE;
            ST_SPLIT_LO: if (tgt_rdy) state_d = ST_SPLIT_HI;
            ST_SPLIT_HI: if (tgt_rdy) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            size_q  <= SZ8;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx_q   <= route_d;
                        size_q  <= req_size;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        rdata_q <= lock_d ? ones_fit : 32'd0;
                    end
                end
                ST_SINGLE: begin
                    if (tgt_rdy && !write_q) rdata_q <= cap_fit;
                end
                ST_SPLIT_LO: begin
                    if (tgt_rdy && !write_q) rdata_q[15:0] <= tgt_rdata[15:0];
                end
                ST_SPLIT_HI: begin
                    if (tgt_rdy && !write_q) rdata_q[31:16] <= tgt_rdata[15:0];
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    aux_sel_decode #(.N(NTGT)) u_sel (
        .en (active),
        .idx(ctx_q.tgt),
        .sel(tgt_sel)
    );

    // output logic
    always_comb begin
        active     = 1'b0;
        tgt_addr   = '0;
        tgt_write  = 1'b0;
        tgt_size   = SZ8;
        tgt_wdata  = '0;
        rsp_valid  = 1'b0;
        rsp_rdata  = '0;
        rsp_region = ctx_q.region;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_SINGLE: begin
                active    = 1'b1;
                tgt_addr  = ctx_q.local_addr;
                tgt_write = write_q;
                tgt_size  = size_q;
                tgt_wdata = wdata_q;
            end
            ST_SPLIT_LO: begin
                active    = 1'b1;
                tgt_addr  = {16'd0, ctx_q.local_addr[15:0]};
                tgt_write = write_q;
                tgt_size  = SZ16;
                tgt_wdata = {16'd0, wdata_q[15:0]};
            end
            ST_SPLIT_HI: begin
                active    = 1'b1;
                tgt_addr  = {16'd0, ctx_q.local_addr[15:0] + 16'd2};
                tgt_write = write_q;
                tgt_size  = SZ16;
                tgt_wdata = {16'd0, wdata_q[31:16]};
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            ST_IDLE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/aux_bus_decoder_chk.sv
module aux_bus_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic [3:0]  rsp_region,
    input logic [6:0]  tgt_sel,
    input logic        tgt_rdy,
    input logic        tgt_write,
    input logic [1:0]  tgt_size,
    input logic [31:0] tgt_addr
);
    // R10: at most one target at a time
    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    // R10: response is a single-cycle pulse
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: an accepted request makes the block busy next cycle
    p_busy_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R10: select and address hold while the target is not ready
    p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((tgt_sel != 7'd0) && !tgt_rdy) |=> ($stable(tgt_sel) && $stable(tgt_addr)));

    // R9: unmapped responses carry zero data
    p_void_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == 4'd0) |-> (rsp_rdata == 32'd0));

    // R1: the BIOS target never sees a write
    p_bios_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[0] |-> !tgt_write);

    // R8: the wireless target only sees 16-bit transfers
    p_wifi_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[5] |-> (tgt_size == 2'd1));

    // R11: nothing selected while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tgt_sel == 7'd0 && !rsp_valid));
endmodule

bind aux_bus_decoder aux_bus_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_region(rsp_region),
    .tgt_sel   (tgt_sel),
    .tgt_rdy   (tgt_rdy),
    .tgt_write (tgt_write),
    .tgt_size  (tgt_size),
    .tgt_addr  (tgt_addr)
);

// File: tb/aux_bus_decoder_test.sv
module aux_bus_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] cpu_pc = '0;
    logic [31:0] bios_bound = '0;
    logic        shared_grant = 1'b0;
    logic [6:0]  tgt_sel;
    logic [31:0] tgt_addr;
    logic        tgt_write;
    logic [1:0]  tgt_size;
    logic [31:0] tgt_wdata;
    logic        tgt_rdy = 1'b0;
    logic [31:0] tgt_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_region;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    aux_bus_decoder uut (.*);

    function automatic logic [31:0] model(int idx, logic [31:0] a);
        return {8'(idx) + 8'h30, a[23:0]} ^ 32'h00A5_5A00;
    endfunction

    always_comb begin
        tgt_rdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 7; i++)
            if (tgt_sel[i]) tgt_rdata = model(i, tgt_addr);
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fit(logic [1:0] sz, logic [31:0] d);
        if (sz == 2'd0) return {24'd0, d[7:0]};
        if (sz == 2'd1) return {16'd0, d[15:0]};
        return d;
    endfunction

    // expected routing, from the requirements
    task automatic ref_route(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                             input bit sh, output int rg, output int idx,
                             output logic [31:0] loc, output string tag);
        rg = 0; idx = -1; loc = '0; tag = "R9";
        if (a < 32'h4000) begin
            tag = "R1";
            if (!wr) begin rg = 1; idx = 0; loc = a & 32'h3FFF; end
        end else begin
            case (a[31:23])
                9'h004, 9'h005: begin rg = 2; idx = 1; loc = a & 32'h3F_FFFF; tag = "R3"; end
                9'h006: begin
                    tag = "R4";
                    if (sh) begin rg = 3; idx = 2; loc = a & 32'h7FFF; end
                    else    begin rg = 4; idx = 3; loc = a & 32'hFFFF; end
                end
                9'h007: begin rg = 4; idx = 3; loc = a & 32'hFFFF; tag = "R5"; end
                9'h008: begin rg = 5; idx = 4; loc = a & 32'hFF_FFFF; tag = "R6"; end
                9'h009: begin
                    tag = "R7";
                    if (a[22:16] == 7'd0 && sz != 2'd0) begin
                        rg = a[15] ? 7 : 6; idx = 5; loc = a & 32'hFFFF;
                    end
                end
                9'h00C, 9'h00D: begin rg = 8; idx = 6; loc = a & 32'h3_FFFF; tag = "R6"; end
                default: ;
            endcase
        end
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] pc,
                          input logic [31:0] gd, input bit sh);
        int rg, idx, hs, nhs;
        logic [31:0] loc, exp_rd, exp_addr;
        string tag;
        bit prot, split, last_done, seen;
        ref_route(a, wr, sz, sh, rg, idx, loc, tag);
        prot  = (rg == 1) && ((pc >= 32'h4000) || (a < gd && pc >= gd));
        split = (rg == 6 || rg == 7) && sz == 2'd2;
        if (prot) tag = "R2";
        if (split) tag = "R8";
        nhs = split ? 2 : ((rg != 0 && !prot) ? 1 : 0);
        if (wr || rg == 0)  exp_rd = 32'd0;
        else if (prot)      exp_rd = fit(sz, 32'hFFFF_FFFF);
        else if (split)     exp_rd = {model(5, {16'd0, loc[15:0] + 16'd2})[15:0], model(5, loc)[15:0]};
        else                exp_rd = fit(sz, model(idx, loc));

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; cpu_pc = pc; bios_bound = gd; shared_grant = sh;
        @(negedge clk);
        req_valid = 1'b0;
        hs = 0; last_done = (nhs == 0); seen = 0;
        for (int it = 0; it < 200; it++) begin
            if (rsp_valid) begin
                seen = 1;
                chk(last_done && hs == nhs, "R10", "response timing/handshakes", 32'(hs), 32'(nhs));
                chk(rsp_region == 4'(rg), tag, "region", 32'(rsp_region), 32'(rg));
                chk(rsp_rdata == exp_rd, tag, "read data", rsp_rdata, exp_rd);
                break;
            end
            chk(!last_done, "R10", "response missing after last handshake", 32'(hs), 32'(nhs));
            chk(busy == 1'b1, "R10", "busy during access", 32'(busy), 32'd1);
            if (tgt_sel != 7'd0) begin
                exp_addr = (hs == 1) ? {16'd0, loc[15:0] + 16'd2} : loc;
                chk(idx >= 0 && tgt_sel == 7'(1 << idx), tag, "select", 32'(tgt_sel), (idx >= 0) ? 32'(1 << idx) : 32'd0);
                chk(tgt_addr == exp_addr, tag, "local address", tgt_addr, exp_addr);
                chk(tgt_write == wr, tag, "write strobe", 32'(tgt_write), 32'(wr));
                chk(tgt_size == (split ? 2'd1 : sz), tag, "size", 32'(tgt_size), split ? 32'd1 : 32'(sz));
                if (wr) begin
                    if (split)
                        chk(tgt_wdata[15:0] == (hs == 0 ? wd[15:0] : wd[31:16]), "R8", "write half",
                            32'(tgt_wdata[15:0]), hs == 0 ? 32'(wd[15:0]) : 32'(wd[31:16]));
                    else
                        chk(tgt_wdata == wd, tag, "write data", tgt_wdata, wd);
                end
                tgt_rdy = (($urandom % 3) != 0);
                if (tgt_rdy) begin
                    hs++;
                    if (hs == nhs) last_done = 1;
                end
            end else begin
                chk(nhs == 0 || hs >= nhs, tag, "select missing", 32'(hs), 32'(nhs));
                tgt_rdy = 1'b0;
            end
            @(negedge clk);
            tgt_rdy = 1'b0;
        end
        tgt_rdy = 1'b0;
        if (!seen) chk(1'b0, "R10", "no response", 32'd0, 32'd1);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] bases [12];
        void'($urandom(32'd24681));
        bases = '{32'h0000_0000, 32'h0200_0000, 32'h0280_0000, 32'h0300_0000,
                  32'h0380_0000, 32'h0400_0000, 32'h0480_0000, 32'h0600_0000,
                  32'h0680_0000, 32'h0500_0000, 32'h0800_0000, 32'hFFFF_0000};
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy in reset", 32'(busy), 32'd0);
        chk(rsp_valid == 1'b0, "R11", "rsp in reset", 32'(rsp_valid), 32'd0);
        chk(tgt_sel == 7'd0, "R11", "select in reset", 32'(tgt_sel), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && tgt_sel == 7'd0, "R11", "idle after reset", 32'(busy), 32'd0);

        // R1 / R2 BIOS
        access(32'h0000_0020, 0, 2'd2, 0, 32'h100, 32'h1000, 0);
        access(32'h0000_0021, 0, 2'd0, 0, 32'h5000, 32'h1000, 0);
        access(32'h0000_0800, 0, 2'd1, 0, 32'h2000, 32'h1000, 0);
        access(32'h0000_1800, 0, 2'd1, 0, 32'h2000, 32'h1000, 0);
        access(32'h0000_0040, 0, 2'd2, 0, 32'h0000_3FFC, 32'h0, 0);
        access(32'h0000_0040, 1, 2'd2, 32'h1234_5678, 32'h100, 32'h0, 0);
        // R3 main RAM
        access(32'h0280_1234, 0, 2'd2, 0, 0, 0, 0);
        access(32'h0200_0102, 1, 2'd1, 32'h0000_BEEF, 0, 0, 0);
        // R4 / R5 shared and private
        access(32'h0301_2344, 0, 2'd2, 0, 0, 0, 1);
        access(32'h0301_2344, 0, 2'd2, 0, 0, 0, 0);
        access(32'h0380_ABCC, 0, 2'd0, 0, 0, 0, 1);
        // R6 I/O and video
        access(32'h0400_0208, 0, 2'd1, 0, 0, 0, 0);
        access(32'h0680_0010, 0, 2'd2, 0, 0, 0, 0);
        // R7 wireless
        access(32'h0480_8000, 0, 2'd1, 0, 0, 0, 0);
        access(32'h0480_0100, 0, 2'd1, 0, 0, 0, 0);
        access(32'h0481_0000, 0, 2'd1, 0, 0, 0, 0);
        access(32'h0480_0101, 0, 2'd0, 0, 0, 0, 0);
        // R8 split
        access(32'h0480_8004, 0, 2'd2, 0, 0, 0, 0);
        access(32'h0480_00FC, 1, 2'd2, 32'hCAFE_F00D, 0, 0, 0);
        access(32'h0480_FFFE, 0, 2'd2, 0, 0, 0, 0);
        // R9 unmapped
        access(32'h0500_0000, 0, 2'd2, 0, 0, 0, 0);
        access(32'h0800_0010, 0, 2'd1, 0, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, pc, gd;
            logic [1:0] sz;
            int b;
            b  = $urandom % 12;
            sz = 2'($urandom % 3);
            a  = bases[b] + (b == 6 ? ($urandom & 32'h0001_FFFF) : ($urandom & 32'h007F_FFFF));
            if (b == 0) a = $urandom & 32'h0000_7FFF;
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz == 2'd2) a[1:0] = 2'b00;
            case ($urandom % 4)
                0: pc = 32'h0000_0100;
                1: pc = 32'h0000_3000;
                2: pc = 32'h0000_4000;
                default: pc = 32'h0200_0000;
            endcase
            gd = $urandom & 32'h0000_3FFF;
            access(a, 1'($urandom % 2), sz, $urandom, pc, gd, 1'($urandom % 2));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule